// File: doc/BRIEF.md
# Driver Fault Latch and Error Flag

This block gathers the protection events of a two-coil H-bridge motor driver and turns them into status flags, a driver-disable control and one active-low error line meant for an open-drain pad. Its inputs are already-digitised comparator levels: a thermal warning, a thermal shutdown, one overcurrent comparator per bridge transistor on the X and Y bridges, one "PWM at 100% duty" indicator per coil and a charge-pump-good level. A status-read strobe and an overcurrent-clear strobe stand in for the register bus.

Each flag follows its own rule. The warning flag tracks its comparator. The shutdown flag latches and is released only by a status read taken while both temperature comparators are low. Overcurrent flags latch per transistor until the host clears them. An open-coil flag needs a coil to stay at full duty for more than a set number of time-base ticks. The charge-pump flag is high while the pump is not good, which includes the time just after reset. Shutdown and any overcurrent switch the drivers off. An open coil does not, so the coil current keeps flowing.

Top module: `fault_monitor`

## Requirements
- R1: `flag_tw_o` equals the value `temp_warn_i` had at the previous clock edge.
- R2: `temp_shdn_i` high at a clock edge sets `flag_tsd_o` and `drv_off_o` after that edge.
- R3: `flag_tsd_o` clears only at an edge where `stat_rd_i` is high and both `temp_warn_i` and `temp_shdn_i` are low. A read taken while the warning comparator is high leaves it set.
- R4: Bit i of `ovc_x_i` (or `ovc_y_i`) high at an edge sets bit i of `flag_ovc_x_o` (or `flag_ovc_y_o`) and no other bit, and asserts `drv_off_o`.
- R5: Overcurrent flags hold until an edge with `ovc_clr_i` high. A status read does not clear them. At a clear edge, a bit whose comparator is still high stays set.
- R6: `flag_open_o[c]` sets after the (OPEN_TICKS+1)-th `tick_i` counted while `duty_full_i[c]` stays high. Any edge with `duty_full_i[c]` low clears the flag and restarts the count. This flag does not assert `drv_off_o`.
- R7: `flag_cpf_o` equals the inverse of `cp_good_i` at the previous edge, and it is 1 during and right after reset.
- R8: `err_n_o` is low exactly when any flag output is set.
- R9: `drv_off_o` is high exactly when `flag_tsd_o` or any overcurrent flag is set. Clearing the shutdown flag while an overcurrent flag remains keeps the drivers off.
- R10: While `rst_n` is low, every flag is 0 except `flag_cpf_o`, `drv_off_o` is 0 and `err_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_warn_i | input | 1 | Thermal warning comparator level |
| temp_shdn_i | input | 1 | Thermal shutdown comparator level |
| ovc_x_i | input | N_SW | Overcurrent comparators, X bridge transistors |
| ovc_y_i | input | N_SW | Overcurrent comparators, Y bridge transistors |
| duty_full_i | input | N_COIL | Per coil: PWM regulator at 100% duty |
| tick_i | input | 1 | One-cycle time-base pulse for open-coil timing |
| cp_good_i | input | 1 | Charge pump above its threshold |
| stat_rd_i | input | 1 | Status read strobe |
| ovc_clr_i | input | 1 | Overcurrent flag clear strobe |
| flag_tw_o | output | 1 | Thermal warning flag |
| flag_tsd_o | output | 1 | Thermal shutdown flag |
| flag_ovc_x_o | output | N_SW | Latched X bridge overcurrent flags |
| flag_ovc_y_o | output | N_SW | Latched Y bridge overcurrent flags |
| flag_open_o | output | N_COIL | Open-coil flags |
| flag_cpf_o | output | 1 | Charge pump failure flag |
| drv_off_o | output | 1 | Forces all bridge transistors to high impedance |
| err_n_o | output | 1 | Active-low combined error |

## Verification
A sequence of vectors first heats the die through warning and shutdown. It then tries status reads with the warning comparator still high and again with it low, which separates a shutdown flag that clears on any read from one gated by temperature. Overcurrent patterns set single bits on each bridge, then apply a read and a clear while one comparator is still active. This tells per-bit latching apart from bridge-wide latching, and clear priority apart from set priority. Shutdown and overcurrent are combined to show that the drivers stay off after only one of the two sources goes away. Directed open-coil runs apply exactly OPEN_TICKS ticks and then one more, and drop the duty indicator for a single cycle, which exposes off-by-one and missing-restart faults in the timer.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int unsigned BRIDGES = 2;
  typedef enum logic [1:0] {
    TH_COOL = 2'b00,
    TH_WARM = 2'b01,
    TH_SHDN = 2'b10
  } therm_lvl_e;
endpackage

// File: rtl/thermal_latch.sv
module thermal_latch
  import fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic shdn_i,
  input  logic rd_i,
  output logic tw_o,
  output logic tsd_o
);
  therm_lvl_e lvl;
  logic       tw_q, tsd_q;

  always_comb begin
    if (shdn_i)      lvl = TH_SHDN;
    else if (warn_i) lvl = TH_WARM;
    else             lvl = TH_COOL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_q  <= 1'b0;
      tsd_q <= 1'b0;
    end else begin
      tw_q <= warn_i;
      if (lvl == TH_SHDN)                tsd_q <= 1'b1;
      else if (rd_i && lvl == TH_COOL)   tsd_q <= 1'b0;
    end
  end

  assign tw_o  = tw_q;
  assign tsd_o = tsd_q;

  // R2
  tsd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |=> tsd_q);
  // R3
  tsd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_q && !(rd_i && !warn_i)) |=> tsd_q);
endmodule

// File: rtl/ovc_latch.sv
module ovc_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (clr_i ? '0 : flag_q) | set_i;
  end

  assign flag_o = flag_q;

  // R5
  ovc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R4
  ovc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/open_coil_timer.sv
module open_coil_timer #(
  parameter int unsigned OPEN_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic full_i,
  input  logic tick_i,
  output logic open_o
);
  localparam int unsigned CW = $clog2(OPEN_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OPEN_TICKS);

  logic [CW-1:0] cnt_q;
  logic          open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (!full_i) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LIMIT) open_q <= 1'b1;
      else                cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign open_o = open_q;

  // R6
  open_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_i |=> !open_q);
  // R6
  open_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/fault_monitor.sv
module fault_monitor #(
  parameter int unsigned N_SW       = 4,
  parameter int unsigned N_COIL     = 2,
  parameter int unsigned OPEN_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_warn_i,
  input  logic              temp_shdn_i,
  input  logic [N_SW-1:0]   ovc_x_i,
  input  logic [N_SW-1:0]   ovc_y_i,
  input  logic [N_COIL-1:0] duty_full_i,
  input  logic              tick_i,
  input  logic              cp_good_i,
  input  logic              stat_rd_i,
  input  logic              ovc_clr_i,
  output logic              flag_tw_o,
  output logic              flag_tsd_o,
  output logic [N_SW-1:0]   flag_ovc_x_o,
  output logic [N_SW-1:0]   flag_ovc_y_o,
  output logic [N_COIL-1:0] flag_open_o,
  output logic              flag_cpf_o,
  output logic              drv_off_o,
  output logic              err_n_o
);
  import fault_pkg::*;
  localparam int unsigned OVC_W = BRIDGES * N_SW;

  logic [OVC_W-1:0] ovc_flags;
  logic             cpf_q;

  thermal_latch u_therm (
    .clk(clk), .rst_n(rst_n), .warn_i(temp_warn_i), .shdn_i(temp_shdn_i),
    .rd_i(stat_rd_i), .tw_o(flag_tw_o), .tsd_o(flag_tsd_o)
  );

  ovc_latch #(.W(OVC_W)) u_ovc (
    .clk(clk), .rst_n(rst_n), .set_i({ovc_y_i, ovc_x_i}),
    .clr_i(ovc_clr_i), .flag_o(ovc_flags)
  );

  assign flag_ovc_x_o = ovc_flags[N_SW-1:0];
  assign flag_ovc_y_o = ovc_flags[OVC_W-1:N_SW];

  for (genvar c = 0; c < N_COIL; c++) begin : g_coil
    open_coil_timer #(.OPEN_TICKS(OPEN_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .full_i(duty_full_i[c]),
      .tick_i(tick_i), .open_o(flag_open_o[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpf_q <= 1'b1;
    else        cpf_q <= !cp_good_i;
  end
  assign flag_cpf_o = cpf_q;

  assign drv_off_o = flag_tsd_o | (|ovc_flags);
  assign err_n_o   = !(flag_tw_o | flag_tsd_o | (|ovc_flags)
                       | (|flag_open_o) | cpf_q);

  // R7
  cpf_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_good_i |=> flag_cpf_o);
  // R9
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_off_o) |-> (!flag_tsd_o && flag_ovc_x_o == '0 && flag_ovc_y_o == '0));
endmodule

// File: tb/fault_monitor_bench.sv
module fault_monitor_bench;
  localparam int NSW = 4;
  localparam int NCOIL = 2;
  localparam int OT = 4;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tw = 0, sd = 0, tick = 0, cpg = 0, rd = 0, clr = 0;
  logic [NSW-1:0] ox = '0, oy = '0;
  logic [NCOIL-1:0] duty = '0;
  logic f_tw, f_tsd, f_cpf, drv, errn;
  logic [NSW-1:0] f_ox, f_oy;
  logic [NCOIL-1:0] f_open;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_monitor #(.N_SW(NSW), .N_COIL(NCOIL), .OPEN_TICKS(OT)) u_fault_monitor (
    .clk(clk), .rst_n(rst_n), .temp_warn_i(tw), .temp_shdn_i(sd),
    .ovc_x_i(ox), .ovc_y_i(oy), .duty_full_i(duty), .tick_i(tick),
    .cp_good_i(cpg), .stat_rd_i(rd), .ovc_clr_i(clr),
    .flag_tw_o(f_tw), .flag_tsd_o(f_tsd), .flag_ovc_x_o(f_ox),
    .flag_ovc_y_o(f_oy), .flag_open_o(f_open), .flag_cpf_o(f_cpf),
    .drv_off_o(drv), .err_n_o(errn)
  );

  // inputs  [25:13]: tw sd ox[4] oy[4] cpg rd clr
  // expects [12:0] : tw tsd ox[4] oy[4] cpf drv errn
  localparam logic [25:0] VEC [NV] = '{
    26'b0_0_0000_0000_1_0_0__0_0_0000_0000_0_0_1, // R7 pump good
    26'b1_0_0000_0000_1_0_0__1_0_0000_0000_0_0_0, // R1 R8 warning
    26'b1_1_0000_0000_1_0_0__1_1_0000_0000_0_1_0, // R2 shutdown
    26'b1_0_0000_0000_1_1_0__1_1_0000_0000_0_1_0, // R3 read while warm
    26'b0_0_0000_0000_1_0_0__0_1_0000_0000_0_1_0, // R3 cool, no read
    26'b0_0_0000_0000_1_1_0__0_0_0000_0000_0_0_1, // R3 R9 cool read
    26'b0_0_0010_0000_1_0_0__0_0_0010_0000_0_1_0, // R4 X bit 1
    26'b0_0_0000_1000_1_0_0__0_0_0010_1000_0_1_0, // R4 R5 Y bit 3
    26'b0_0_0000_0000_1_1_0__0_0_0010_1000_0_1_0, // R5 read ignored
    26'b0_0_0000_1000_1_0_1__0_0_0000_1000_0_1_0, // R5 set beats clear
    26'b0_0_0000_0000_1_0_1__0_0_0000_0000_0_0_1, // R5 clear
    26'b0_1_0001_0000_1_0_0__0_1_0001_0000_0_1_0, // R9 both sources
    26'b0_0_0000_0000_1_1_0__0_0_0001_0000_0_1_0, // R9 ovc keeps off
    26'b0_0_0000_0000_1_0_1__0_0_0000_0000_0_0_1, // R9 release
    26'b0_0_0000_0000_0_0_0__0_0_0000_0000_1_0_0, // R7 pump fail
    26'b0_0_0000_0000_1_0_0__0_0_0000_0000_0_0_1  // R7 recovers
  };
  string tags [NV];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    tags = '{"R7","R1","R2","R3","R3","R3","R4","R4","R5","R5","R5","R9","R9","R9","R7","R7"};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {f_tw, f_tsd, f_ox, f_oy, f_open, f_cpf, drv, errn},
        {1'b0, 1'b0, 4'h0, 4'h0, 2'b00, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {tw, sd, ox, oy, cpg, rd, clr} = VEC[k][25:13];
      @(posedge clk); #1;
      chk(tags[k], {19'd0, f_tw, f_tsd, f_ox, f_oy, f_cpf, drv, errn}, {19'd0, VEC[k][12:0]});
    end
    @(negedge clk); rd = 0; clr = 0; cpg = 1;
    // R6 open coil timing on coil 0
    duty = 2'b01;
    for (int t = 0; t < OT; t++) tick_once();
    chk("R6", {30'd0, f_open}, 32'd0);
    tick_once();
    chk("R6", {30'd0, f_open}, 32'd1);
    chk("R6", {31'd0, drv}, 32'd0);
    chk("R8", {31'd0, errn}, 32'd0);
    duty = 2'b00;
    @(negedge clk);
    chk("R6", {30'd0, f_open}, 32'd0);
    chk("R8", {31'd0, errn}, 32'd1);
    duty = 2'b10;
    for (int t = 0; t < OT; t++) tick_once();
    chk("R6", {30'd0, f_open}, 32'd0);
    tick_once();
    chk("R6", {30'd0, f_open}, 32'd2);
    duty = 2'b00;
    @(negedge clk);
    // R10 reset reasserted mid-run
    ox = 4'h4; @(negedge clk); ox = 4'h0;
    rst_n = 1'b0; #1;
    chk("R10", {f_ox, f_cpf, drv, errn}, {4'h0, 1'b1, 1'b0, 1'b0});
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule